// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block holds a calendar and clock made of seven byte-wide fields: seconds, minutes, hours, day of week, day of month, month and a two-digit year. An external one-second pulse advances the calendar by one second. The carry runs through every field. The length of each month follows the month and the year, and leap years are handled.

Two mode inputs select the encoding and the hour format. The encoding is either binary or packed BCD. The hour format is either 24-hour, or 12-hour with bit 7 of the hour field marking PM. These modes only change how the next value is computed. Changing a mode never rewrites the stored patterns.

A set input stops all advancing so the host can load fields through a write strobe, a field select and a data bus. An update-in-progress output is raised around each advance. A host that reads fields should wait until this output is low.

Top module: `cal_tod_counter`

## Requirements
- R1: While `rst` is high, and after it drops, the fields read seconds 0, minutes 0, hour 0, day of week 1, day of month 1, month 1 and year 0, and `uip_o` is low.
- R2: Seconds and minutes count 0 to 59, each carrying into the next field on wrap. In 24-hour format (`h24_mode_i`=1) the hour counts 0 to 23, and 23 wraps to 0 with a carry into the day.
- R3: With `bin_mode_i`=1 every field is plain binary. With `bin_mode_i`=0 every field is packed BCD (high nibble tens, low nibble units), so 0x09 steps to 0x10 and 0x59 wraps to 0x00.
- R4: In 12-hour format (`h24_mode_i`=0) the hour holds 1..12 in bits 6:0 and bit 7 is set for PM. 11 steps to 12 with the PM bit toggled. 12 steps to 1 with the PM bit kept. Only the step from 11 PM to 12 AM carries into the day.
- R5: The day of month wraps to 1 after 30 in months 4, 6, 9 and 11, after 28 in month 2 (29 when the year is divisible by 4), and after 31 otherwise. Month 12 wraps to 1 and carries into the year, and year 99 wraps to 0.
- R6: The day of week counts 1 to 7 and steps on every day carry, 7 wrapping to 1.
- R7: While `set_i` is 1, ticks are ignored, `uip_o` stays low, and fields change only by host writes.
- R8: A write happens at a clock edge where `wr_en_i` and `set_i` are both 1. It stores `wr_data_i` into the field picked by `wr_sel_i`: 0 seconds, 1 minutes, 2 hour, 3 day of week, 4 day of month, 5 month, 6 year. Select 7, or any write with `set_i`=0, changes nothing.
- R9: A tick sampled with `set_i`=0 and no update under way raises `uip_o` at the next edge. The fields advance at the edge after that, and `uip_o` falls one edge later. Outside such a window or a write, the fields never change.
- R10: Changing `bin_mode_i` or `h24_mode_i` leaves every stored field bit pattern as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| bin_mode_i | input | 1 | 1 = binary fields, 0 = BCD fields |
| h24_mode_i | input | 1 | 1 = 24-hour hour field, 0 = 12-hour with PM bit |
| set_i | input | 1 | Freezes advancing and enables host writes |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 3 | Field select for the write |
| wr_data_i | input | 8 | Write data |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hour |
| dow_o | output | 8 | Day of week |
| dom_o | output | 8 | Day of month |
| mon_o | output | 8 | Month |
| year_o | output | 8 | Year in century |
| uip_o | output | 1 | Update in progress |

## Verification
Some rules are checked by the assertions on every cycle:
- the fields change only inside an update window or through an accepted write;
- the set input freezes the fields and keeps the status low;
- the status pulse lasts exactly two cycles;
- a minute change from an update always comes with the seconds at zero.

Other rules can only be shown by the bench's scenarios, which load chosen dates and compare the result after one tick:
- the values the calendar steps to, in both encodings and both hour formats;
- the month-length and leap-year rollover;
- the 12-hour noon and midnight transitions;
- keeping the stored patterns across mode changes.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int FW      = 8;
  localparam int HW      = FW / 2;
  localparam int NFIELD  = 7;
  localparam int SEL_W   = $clog2(NFIELD + 1);
  localparam int RADIX   = 10;
  localparam int SEC_TOP = 59;
  localparam int DOW_TOP = 7;
  localparam int MON_TOP = 12;
  localparam int YR_TOP  = 99;
  localparam int HR24_TOP = 23;
  localparam int HR12_TOP = 12;
  localparam int LEAP_MOD = 4;

  typedef enum logic [SEL_W-1:0] {
    F_SEC = 0, F_MIN = 1, F_HOUR = 2, F_DOW = 3, F_DOM = 4, F_MON = 5, F_YEAR = 6
  } field_e;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_SETTLE} seq_e;

  function automatic logic [FW-1:0] to_bin(input logic [FW-1:0] x, input logic bcd);
    if (bcd) return FW'(x[FW-1:HW]) * FW'(RADIX) + FW'(x[HW-1:0]);
    return x;
  endfunction

  function automatic logic [FW-1:0] from_bin(input logic [FW-1:0] v, input logic bcd);
    if (bcd) return {HW'(v / FW'(RADIX)), HW'(v % FW'(RADIX))};
    return v;
  endfunction

  function automatic logic [FW-1:0] reset_val(input int idx);
    if (idx == int'(F_DOW) || idx == int'(F_DOM) || idx == int'(F_MON)) return FW'(1);
    return '0;
  endfunction
endpackage

// File: rtl/cal_field_step.sv
module cal_field_step
  import cal_pkg::*;
#(
  parameter int LO = 0
) (
  input  logic [FW-1:0] cur_i,
  input  logic [FW-1:0] top_i,
  input  logic          bcd_i,
  input  logic          cin_i,
  output logic [FW-1:0] nxt_o,
  output logic          cout_o
);
  logic [FW-1:0] cur_b, nxt_b;
  logic          wrap;

  always_comb begin
    cur_b  = to_bin(cur_i, bcd_i);
    wrap   = (cur_b >= top_i);
    nxt_b  = wrap ? FW'(LO) : cur_b + FW'(1);
    nxt_o  = cin_i ? from_bin(nxt_b, bcd_i) : cur_i;
    cout_o = cin_i && wrap;
  end
endmodule

// File: rtl/cal_hour_step.sv
module cal_hour_step
  import cal_pkg::*;
(
  input  logic [FW-1:0] cur_i,
  input  logic          bcd_i,
  input  logic          h24_i,
  input  logic          cin_i,
  output logic [FW-1:0] nxt_o,
  output logic          cout_o
);
  logic [FW-1:0] full_b, half_b, step_b, enc;
  logic          pm, pm_n, wrap;

  always_comb begin
    pm     = cur_i[FW-1];
    full_b = to_bin(cur_i, bcd_i);
    half_b = to_bin({1'b0, cur_i[FW-2:0]}, bcd_i);
    pm_n   = pm;
    wrap   = 1'b0;
    if (h24_i) begin
      wrap   = (full_b >= FW'(HR24_TOP));
      step_b = wrap ? '0 : full_b + FW'(1);
      enc    = from_bin(step_b, bcd_i);
    end else begin
      if (half_b == FW'(HR12_TOP - 1)) begin
        step_b = FW'(HR12_TOP);
        pm_n   = ~pm;
        wrap   = pm;
      end else if (half_b >= FW'(HR12_TOP) || half_b == '0) begin
        step_b = FW'(1);
      end else begin
        step_b = half_b + FW'(1);
      end
      enc = from_bin(step_b, bcd_i);
      enc[FW-1] = pm_n;
    end
    nxt_o  = cin_i ? enc : cur_i;
    cout_o = cin_i && wrap;
  end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
(
  input  logic [FW-1:0] mon_i,
  input  logic [FW-1:0] yr_i,
  input  logic          bcd_i,
  output logic [FW-1:0] days_o
);
  logic [FW-1:0] mb, yb;

  always_comb begin
    mb = to_bin(mon_i, bcd_i);
    yb = to_bin(yr_i, bcd_i);
    case (mb)
      FW'(2):                   days_o = (yb % FW'(LEAP_MOD) == '0) ? FW'(29) : FW'(28);
      FW'(4), FW'(6), FW'(9), FW'(11): days_o = FW'(30);
      default:                  days_o = FW'(31);
    endcase
  end
endmodule

// File: rtl/cal_tod_counter.sv
module cal_tod_counter
  import cal_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             bin_mode_i,
  input  logic             h24_mode_i,
  input  logic             set_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [FW-1:0]    wr_data_i,
  output logic [FW-1:0]    sec_o,
  output logic [FW-1:0]    min_o,
  output logic [FW-1:0]    hour_o,
  output logic [FW-1:0]    dow_o,
  output logic [FW-1:0]    dom_o,
  output logic [FW-1:0]    mon_o,
  output logic [FW-1:0]    year_o,
  output logic             uip_o
);
  logic [FW-1:0] fld_q [NFIELD];
  logic [FW-1:0] fld_n [NFIELD];
  logic [FW-1:0] days;
  logic          bcd;
  logic          c_sec, c_min, c_hour, c_dow, c_dom, c_mon, c_year;
  seq_e          st_q, st_n;
  logic          uip_q;

  assign bcd = ~bin_mode_i;

  cal_field_step #(.LO(0)) u_sec (
    .cur_i(fld_q[F_SEC]), .top_i(FW'(SEC_TOP)), .bcd_i(bcd), .cin_i(1'b1),
    .nxt_o(fld_n[F_SEC]), .cout_o(c_sec));

  cal_field_step #(.LO(0)) u_min (
    .cur_i(fld_q[F_MIN]), .top_i(FW'(SEC_TOP)), .bcd_i(bcd), .cin_i(c_sec),
    .nxt_o(fld_n[F_MIN]), .cout_o(c_min));

  cal_hour_step u_hour (
    .cur_i(fld_q[F_HOUR]), .bcd_i(bcd), .h24_i(h24_mode_i), .cin_i(c_min),
    .nxt_o(fld_n[F_HOUR]), .cout_o(c_hour));

  cal_field_step #(.LO(1)) u_dow (
    .cur_i(fld_q[F_DOW]), .top_i(FW'(DOW_TOP)), .bcd_i(bcd), .cin_i(c_hour),
    .nxt_o(fld_n[F_DOW]), .cout_o(c_dow));

  cal_month_len u_mlen (
    .mon_i(fld_q[F_MON]), .yr_i(fld_q[F_YEAR]), .bcd_i(bcd), .days_o(days));

  cal_field_step #(.LO(1)) u_dom (
    .cur_i(fld_q[F_DOM]), .top_i(days), .bcd_i(bcd), .cin_i(c_hour),
    .nxt_o(fld_n[F_DOM]), .cout_o(c_dom));

  cal_field_step #(.LO(1)) u_mon (
    .cur_i(fld_q[F_MON]), .top_i(FW'(MON_TOP)), .bcd_i(bcd), .cin_i(c_dom),
    .nxt_o(fld_n[F_MON]), .cout_o(c_mon));

  cal_field_step #(.LO(0)) u_year (
    .cur_i(fld_q[F_YEAR]), .top_i(FW'(YR_TOP)), .bcd_i(bcd), .cin_i(c_mon),
    .nxt_o(fld_n[F_YEAR]), .cout_o(c_year));

  // Update sequencer: announce, advance, settle.
  always_comb begin
    st_n = st_q;
    case (st_q)
      ST_IDLE:   if (tick_i && !set_i) st_n = ST_ARM;
      ST_ARM:    st_n = ST_SETTLE;
      default:   st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      uip_q <= 1'b0;
      for (int i = 0; i < NFIELD; i++) fld_q[i] <= reset_val(i);
    end else begin
      st_q  <= st_n;
      uip_q <= (st_n != ST_IDLE);
      if (st_q == ST_ARM && !set_i) begin
        for (int i = 0; i < NFIELD; i++) fld_q[i] <= fld_n[i];
      end else if (set_i && wr_en_i && wr_sel_i < SEL_W'(NFIELD)) begin
        fld_q[wr_sel_i] <= wr_data_i;
      end
    end
  end

  assign sec_o  = fld_q[F_SEC];
  assign min_o  = fld_q[F_MIN];
  assign hour_o = fld_q[F_HOUR];
  assign dow_o  = fld_q[F_DOW];
  assign dom_o  = fld_q[F_DOM];
  assign mon_o  = fld_q[F_MON];
  assign year_o = fld_q[F_YEAR];
  assign uip_o  = uip_q;

  logic [NFIELD*FW-1:0] snap;
  assign snap = {sec_o, min_o, hour_o, dow_o, dom_o, mon_o, year_o};

  a_r7_set_holds: assert property (@(posedge clk) disable iff (rst)
    (set_i && !wr_en_i) |=> $stable(snap));

  a_r7_no_uip_in_set: assert property (@(posedge clk) disable iff (rst)
    (set_i && !uip_o) |=> !uip_o);

  a_r9_change_gated: assert property (@(posedge clk) disable iff (rst)
    !$stable(snap) |-> ($past(uip_o && !set_i) || $past(set_i && wr_en_i)));

  a_r9_uip_two_cycles: assert property (@(posedge clk) disable iff (rst)
    $rose(uip_o) |=> uip_o);

  a_r9_uip_falls: assert property (@(posedge clk) disable iff (rst)
    (uip_o && $past(uip_o)) |=> !uip_o);

  a_r2_min_needs_sec_wrap: assert property (@(posedge clk) disable iff (rst)
    (!$past(set_i) && $past(uip_o) && !$stable(min_o)) |-> (sec_o == '0));
endmodule

// File: tb/test_cal_tod_counter.sv
`timescale 1ns/1ps
module test_cal_tod_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, bin_mode = 1'b0, h24 = 1'b1, set = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] sec, mn, hr, dow, dom, mon, yr;
  logic uip;

  int tests = 0, fails = 0;
  bit done = 0;

  typedef struct { string req; logic [55:0] f; logic u; } item_t;
  item_t q[$];
  logic [55:0] exp_now;

  always #4 clk = ~clk;

  cal_tod_counter i_cal_tod_counter (
    .clk(clk), .rst(rst), .tick_i(tick), .bin_mode_i(bin_mode), .h24_mode_i(h24),
    .set_i(set), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .sec_o(sec), .min_o(mn), .hour_o(hr), .dow_o(dow), .dom_o(dom), .mon_o(mon),
    .year_o(yr), .uip_o(uip));

  function automatic logic [55:0] pk(input logic [7:0] s, m, h, dw, dm, mo, y);
    return {s, m, h, dw, dm, mo, y};
  endfunction

  // Monitor: compares queued expectations a moment after each falling edge.
  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      tests++;
      if ({sec, mn, hr, dow, dom, mon, yr} !== it.f || uip !== it.u) begin
        fails++;
        $display("FAIL %s: got fields=%h uip=%b, expected fields=%h uip=%b",
                 it.req, {sec, mn, hr, dow, dom, mon, yr}, uip, it.f, it.u);
      end
    end
  end

  task automatic push(input logic [55:0] f, input logic u, input string req);
    item_t it;
    it.req = req; it.f = f; it.u = u;
    q.push_back(it);
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic load(input logic [55:0] f);
    @(negedge clk); set = 1'b1;
    for (int i = 0; i < 7; i++) wr(3'(i), f[55 - 8*i -: 8]);
    @(negedge clk); set = 1'b0;
    exp_now = f;
  endtask

  task automatic do_tick(input logic [55:0] nxt, input bit look, input logic mid_u,
                         input string req);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    if (look) push(exp_now, mid_u, req);
    @(negedge clk);
    if (look && mid_u) push(nxt, 1'b1, req);
    @(negedge clk);
    exp_now = nxt;
    push(exp_now, 1'b0, req);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got running, expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset values while reset is held and after release
    exp_now = pk(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    push(exp_now, 1'b0, "R1");
    @(negedge clk); rst = 1'b0;
    @(negedge clk); push(exp_now, 1'b0, "R1");

    // BCD 24-hour: R8 load, R9 status window, R2 R5 R6 full rollover
    bin_mode = 1'b0; h24 = 1'b1;
    load(pk(8'h58, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99));
    @(negedge clk); push(exp_now, 1'b0, "R8");
    do_tick(pk(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99), 1, 1'b1, "R9");
    do_tick(pk(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00), 0, 1'b0, "R2 R5 R6");

    // R3 BCD digit carry into minutes
    load(pk(8'h59, 8'h09, 8'h12, 8'h02, 8'h15, 8'h06, 8'h21));
    do_tick(pk(8'h00, 8'h10, 8'h12, 8'h02, 8'h15, 8'h06, 8'h21), 0, 1'b0, "R3");

    // R3 R5 binary, February in a non-leap year
    bin_mode = 1'b1;
    load(pk(8'h3B, 8'h3B, 8'h17, 8'h03, 8'h1C, 8'h02, 8'h17));
    do_tick(pk(8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h03, 8'h17), 0, 1'b0, "R3 R5");

    // R5 leap year: 28 -> 29, then 29 -> March 1
    load(pk(8'h3B, 8'h3B, 8'h17, 8'h05, 8'h1C, 8'h02, 8'h18));
    do_tick(pk(8'h00, 8'h00, 8'h00, 8'h06, 8'h1D, 8'h02, 8'h18), 0, 1'b0, "R5");
    load(pk(8'h3B, 8'h3B, 8'h17, 8'h06, 8'h1D, 8'h02, 8'h18));
    do_tick(pk(8'h00, 8'h00, 8'h00, 8'h07, 8'h01, 8'h03, 8'h18), 0, 1'b0, "R5");

    // R5 30-day month in BCD
    bin_mode = 1'b0;
    load(pk(8'h59, 8'h59, 8'h23, 8'h04, 8'h30, 8'h04, 8'h25));
    do_tick(pk(8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h05, 8'h25), 0, 1'b0, "R5");

    // R4 12-hour BCD transitions
    h24 = 1'b0;
    load(pk(8'h59, 8'h59, 8'h11, 8'h01, 8'h10, 8'h03, 8'h25));
    do_tick(pk(8'h00, 8'h00, 8'h92, 8'h01, 8'h10, 8'h03, 8'h25), 0, 1'b0, "R4");
    load(pk(8'h59, 8'h59, 8'h92, 8'h01, 8'h10, 8'h03, 8'h25));
    do_tick(pk(8'h00, 8'h00, 8'h81, 8'h01, 8'h10, 8'h03, 8'h25), 0, 1'b0, "R4");
    load(pk(8'h59, 8'h59, 8'h91, 8'h02, 8'h10, 8'h03, 8'h25));
    do_tick(pk(8'h00, 8'h00, 8'h12, 8'h03, 8'h11, 8'h03, 8'h25), 0, 1'b0, "R4");
    load(pk(8'h59, 8'h59, 8'h12, 8'h03, 8'h11, 8'h03, 8'h25));
    do_tick(pk(8'h00, 8'h00, 8'h01, 8'h03, 8'h11, 8'h03, 8'h25), 0, 1'b0, "R4");

    // R4 R5 R6 binary 12-hour, end of century
    bin_mode = 1'b1;
    load(pk(8'h3B, 8'h3B, 8'h8B, 8'h07, 8'h1F, 8'h0C, 8'h63));
    do_tick(pk(8'h00, 8'h00, 8'h0C, 8'h01, 8'h01, 8'h01, 8'h00), 0, 1'b0, "R4 R5 R6");

    // R7 ticks ignored while set is held
    @(negedge clk); set = 1'b1;
    do_tick(exp_now, 1, 1'b0, "R7");
    @(negedge clk); set = 1'b0;

    // R8 write without set is ignored
    wr(3'd0, 8'h2A);
    @(negedge clk); push(exp_now, 1'b0, "R8");

    // R8 select 7 is ignored even under set
    @(negedge clk); set = 1'b1;
    wr(3'd7, 8'hFF);
    @(negedge clk); set = 1'b0;
    @(negedge clk); push(exp_now, 1'b0, "R8");

    // R10 mode change keeps stored patterns
    bin_mode = 1'b0; h24 = 1'b0;
    load(pk(8'h45, 8'h30, 8'h08, 8'h02, 8'h05, 8'h05, 8'h20));
    @(negedge clk); bin_mode = 1'b1; h24 = 1'b1;
    @(negedge clk); @(negedge clk);
    push(exp_now, 1'b0, "R10");

    repeat (4) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule